// File: doc/BRIEF.md
# Serial Command VRAM Write Controller

This block takes 16-bit command words from a three-wire serial link and applies them to the character memory of an on-screen display. The link has an active-low select, a data line and a shift clock. The top four bits of each word select a command group. Character cells are arranged as 16 rows by 32 columns, and each row also has one attribute word. Both memories are held inside the block. A combinational read port exposes them to the display side and to the bench.

Writing one character takes two commands. The first command stages colours and modes. The second command adds the code and flag bits, writes the full cell at the current address and moves the address forward. A row attribute is built the same way from two commands, but only the row address applies to it. A bulk fill writes one character value into every cell from the current address to the last cell of the screen, and the busy output stays high while it runs. While the horizontal sync input is high, all memory writes wait.

The serial link cannot be stalled, so the interface has no back-pressure. The sender must leave a gap of at least four clock cycles after each word before the next word completes. Every write request is held until it finishes; none is dropped.

Top module: `osd_cmd_vram`

## Requirements
- R1: A word is built from 16 bits. Each bit is sampled on a rising shift clock while select is low, most significant bit first. The word is accepted when select rises. Bits 15-12 select the command: 0 address, 1 character stage, 2 character write, 3 row stage, 4 row write, 5 screen enables, 13 pin polarity.
- R2: A frame that ends with any bit count other than 16 is discarded. It leaves the memories, the address and the staged data unchanged.
- R3: Command 0 loads the row address from bits 11-8 and the column address from bits 4-0. It sets the fill flag from bit 7.
- R4: Command 1 only stages its bits 11-0, and no cell changes. Command 2 writes the cell {cmd2[11:0], staged[11:0]} (24 bits) at the current address, then advances the column.
- R5: Advancing from column 31 goes to column 0 of the next row. Advancing from row 15, column 31 goes to row 0, column 0.
- R6: Command 3 stages bits 11-0. Command 4 writes the row attribute {cmd4[11:0], staged[11:0]} to the addressed row. It ignores the column, does not advance the address and changes no cell.
- R7: When the fill flag is set, command 2 writes the same cell value to every cell from the current address through row 15, column 31, one cell per clock. With sync low, busy is high for exactly as many cycles as cells are written. Cells before the start address are untouched.
- R8: While hsync is high, no write takes place. A pending write, or a fill in progress, continues once hsync falls.
- R9: While busy is high, commands 0 to 4 are ignored.
- R10: Command 5 with bits 11-8 equal to zero loads scr_en from bits 7-4. Command 13 with bits 11-8 equal to zero loads out_pol from bits 1-0. Reset clears scr_en, out_pol and busy. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial shift clock; data sampled on its rising edge |
| hsync | input | 1 | High during the horizontal sync pulse; suspends writes |
| rd_row | input | 4 | Read port row index |
| rd_col | input | 5 | Read port column index |
| rd_cell | output | 24 | Cell stored at rd_row, rd_col |
| rd_rowattr | output | 24 | Row attribute stored at rd_row |
| busy | output | 1 | High while a bulk fill runs |
| scr_en | output | 4 | Screen layer enable bits |
| out_pol | output | 2 | Output polarity bits |

## Verification
The character path is driven with single writes in the middle of a row, at the last column of a row and at the last cell of the screen. These three cases separate plain increment, row carry and screen wrap. Row-attribute writes are checked against a later character write that must land at the same column, which shows the address did not move. Short and long frames, as well as staging without a write, are confirmed to leave cells unchanged. Fills are run both with sync low, where the busy length must match the cell count, and with sync held high, where commands sent meanwhile must have no effect.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 12;
  localparam int ATTR_W  = 2 * FIELD_W;

  typedef enum logic [3:0] {
    GRP_ADDR   = 4'd0,
    GRP_CHR_ST = 4'd1,
    GRP_CHR_WR = 4'd2,
    GRP_ROW_ST = 4'd3,
    GRP_ROW_WR = 4'd4,
    GRP_SCREEN = 4'd5,
    GRP_PINCTL = 4'd13
  } cmd_grp_e;
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sdat_i,
  input  logic              sclk_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [2:0]        cs_s, ck_s;
  logic [1:0]        dt_s;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              shift_en, frame_end;

  assign shift_en  = ck_s[1] & ~ck_s[2] & ~cs_s[1];
  assign frame_end = cs_s[1] & ~cs_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s       <= '1;
      ck_s       <= '0;
      dt_s       <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      cs_s       <= {cs_s[1:0], cs_n_i};
      ck_s       <= {ck_s[1:0], sclk_i};
      dt_s       <= {dt_s[0], sdat_i};
      word_vld_o <= 1'b0;
      if (frame_end) begin
        if (cnt_q == CNT_FULL) begin
          word_vld_o <= 1'b1;
          word_o     <= sh_q;
        end
        cnt_q <= '0;
      end else if (shift_en) begin
        sh_q <= {sh_q[WORD_W-2:0], dt_s[1]};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1
  frame_at_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> cs_s[2]);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/osd_cmd_ctrl.sv
module osd_cmd_ctrl
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_vld_i,
  input  logic [WORD_W-1:0]        word_i,
  input  logic                     hsync_i,
  output logic                     wr_cell_o,
  output logic [$clog2(ROWS)-1:0]  cell_row_o,
  output logic [$clog2(COLS)-1:0]  cell_col_o,
  output logic [ATTR_W-1:0]        cell_data_o,
  output logic                     wr_row_o,
  output logic [$clog2(ROWS)-1:0]  row_idx_o,
  output logic [ATTR_W-1:0]        row_data_o,
  output logic                     busy_o,
  output logic [3:0]               scr_en_o,
  output logic [1:0]               pol_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [ROW_W-1:0]   row_q, row_nx, rrow_q;
  logic [COL_W-1:0]   col_q, col_nx;
  logic               fill_q, busy_q, pend_c_q, pend_r_q;
  logic [FIELD_W-1:0] stage_c_q, stage_r_q;
  logic [ATTR_W-1:0]  data_c_q, data_r_q;
  logic [3:0]         en_q;
  logic [1:0]         pol_q;
  cmd_grp_e           grp;
  logic               last_cell;

  assign grp       = cmd_grp_e'(word_i[WORD_W-1 -: 4]);
  assign last_cell = (row_q == ROW_LAST) && (col_q == COL_LAST);

  always_comb begin
    if (col_q == COL_LAST) begin
      col_nx = '0;
      row_nx = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    end else begin
      col_nx = col_q + 1'b1;
      row_nx = row_q;
    end
  end

  assign wr_cell_o   = (pend_c_q | busy_q) & ~hsync_i;
  assign wr_row_o    = pend_r_q & ~hsync_i;
  assign cell_row_o  = row_q;
  assign cell_col_o  = col_q;
  assign cell_data_o = data_c_q;
  assign row_idx_o   = rrow_q;
  assign row_data_o  = data_r_q;
  assign busy_o      = busy_q;
  assign scr_en_o    = en_q;
  assign pol_o       = pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      rrow_q    <= '0;
      fill_q    <= 1'b0;
      busy_q    <= 1'b0;
      pend_c_q  <= 1'b0;
      pend_r_q  <= 1'b0;
      stage_c_q <= '0;
      stage_r_q <= '0;
      data_c_q  <= '0;
      data_r_q  <= '0;
      en_q      <= '0;
      pol_q     <= '0;
    end else begin
      if (wr_cell_o) begin
        row_q    <= row_nx;
        col_q    <= col_nx;
        pend_c_q <= 1'b0;
        if (busy_q && last_cell) busy_q <= 1'b0;
      end
      if (wr_row_o) pend_r_q <= 1'b0;
      if (word_vld_i) begin
        unique case (grp)
          GRP_ADDR: if (!busy_q) begin
            row_q  <= word_i[11:8];
            col_q  <= word_i[COL_W-1:0];
            fill_q <= word_i[7];
          end
          GRP_CHR_ST: if (!busy_q) stage_c_q <= word_i[FIELD_W-1:0];
          GRP_CHR_WR: if (!busy_q) begin
            data_c_q <= {word_i[FIELD_W-1:0], stage_c_q};
            if (fill_q) busy_q   <= 1'b1;
            else        pend_c_q <= 1'b1;
          end
          GRP_ROW_ST: if (!busy_q) stage_r_q <= word_i[FIELD_W-1:0];
          GRP_ROW_WR: if (!busy_q) begin
            data_r_q <= {word_i[FIELD_W-1:0], stage_r_q};
            rrow_q   <= row_q;
            pend_r_q <= 1'b1;
          end
          GRP_SCREEN: if (word_i[11:8] == 4'h0) en_q  <= word_i[7:4];
          GRP_PINCTL: if (word_i[11:8] == 4'h0) pol_q <= word_i[1:0];
          default: ;
        endcase
      end
    end
  end

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cell_o && col_q != COL_LAST && !word_vld_i) |=> (col_q == $past(col_q) + 1'b1));
  // R5
  screen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cell_o && last_cell && !word_vld_i) |=> (row_q == '0 && col_q == '0));
  // R6
  row_write_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_row_o && !wr_cell_o && !word_vld_i) |=> ($stable(row_q) && $stable(col_q)));
  // R9
  busy_no_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pend_c_q);
  // R7
  fill_ends_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (row_q == '0 && col_q == '0));
endmodule

// File: rtl/osd_vram_store.sv
module osd_vram_store #(
  parameter int ROWS   = 16,
  parameter int COLS   = 32,
  parameter int ATTR_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hsync_i,
  input  logic                    wr_cell_i,
  input  logic [$clog2(ROWS)-1:0] wr_row_i,
  input  logic [$clog2(COLS)-1:0] wr_col_i,
  input  logic [ATTR_W-1:0]       wr_cdata_i,
  input  logic                    wr_rattr_i,
  input  logic [$clog2(ROWS)-1:0] wr_ridx_i,
  input  logic [ATTR_W-1:0]       wr_rdata_i,
  input  logic [$clog2(ROWS)-1:0] rd_row_i,
  input  logic [$clog2(COLS)-1:0] rd_col_i,
  output logic [ATTR_W-1:0]       rd_cell_o,
  output logic [ATTR_W-1:0]       rd_rattr_o
);
  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = $clog2(CELLS);

  logic [ATTR_W-1:0] cell_mem [CELLS];
  logic [ATTR_W-1:0] row_mem  [ROWS];
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  assign wr_idx = IDX_W'(wr_row_i) * IDX_W'(COLS) + IDX_W'(wr_col_i);
  assign rd_idx = IDX_W'(rd_row_i) * IDX_W'(COLS) + IDX_W'(rd_col_i);

  always_ff @(posedge clk) begin
    if (wr_cell_i)  cell_mem[wr_idx]   <= wr_cdata_i;
    if (wr_rattr_i) row_mem[wr_ridx_i] <= wr_rdata_i;
  end

  assign rd_cell_o  = cell_mem[rd_idx];
  assign rd_rattr_o = row_mem[rd_row_i];

  // R8
  no_write_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i |-> !(wr_cell_i || wr_rattr_i));
endmodule

// File: rtl/osd_cmd_vram.sv
module osd_cmd_vram
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_cs_n,
  input  logic                    ser_dat,
  input  logic                    ser_clk,
  input  logic                    hsync,
  input  logic [$clog2(ROWS)-1:0] rd_row,
  input  logic [$clog2(COLS)-1:0] rd_col,
  output logic [ATTR_W-1:0]       rd_cell,
  output logic [ATTR_W-1:0]       rd_rowattr,
  output logic                    busy,
  output logic [3:0]              scr_en,
  output logic [1:0]              out_pol
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              wr_cell, wr_rattr;
  logic [ROW_W-1:0]  c_row, r_idx;
  logic [COL_W-1:0]  c_col;
  logic [ATTR_W-1:0] c_data, r_data;

  osd_ser_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n_i(ser_cs_n), .sdat_i(ser_dat),
    .sclk_i(ser_clk), .word_vld_o(word_vld), .word_o(word)
  );

  osd_cmd_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_i(word),
    .hsync_i(hsync), .wr_cell_o(wr_cell), .cell_row_o(c_row),
    .cell_col_o(c_col), .cell_data_o(c_data), .wr_row_o(wr_rattr),
    .row_idx_o(r_idx), .row_data_o(r_data), .busy_o(busy),
    .scr_en_o(scr_en), .pol_o(out_pol)
  );

  osd_vram_store #(.ROWS(ROWS), .COLS(COLS), .ATTR_W(ATTR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .wr_cell_i(wr_cell),
    .wr_row_i(c_row), .wr_col_i(c_col), .wr_cdata_i(c_data),
    .wr_rattr_i(wr_rattr), .wr_ridx_i(r_idx), .wr_rdata_i(r_data),
    .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_cell_o(rd_cell),
    .rd_rattr_o(rd_rowattr)
  );
endmodule

// File: tb/sim_osd_cmd_vram.sv
module sim_osd_cmd_vram;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_cs_n = 1'b1, ser_dat = 1'b0, ser_clk = 1'b0, hsync = 1'b0;
  logic [3:0]  rd_row = '0;
  logic [4:0]  rd_col = '0;
  logic [23:0] rd_cell, rd_rowattr;
  logic        busy;
  logic [3:0]  scr_en;
  logic [1:0]  out_pol;

  int n_chk = 0, n_bad = 0;
  int busy_cyc = 0;
  bit done = 0;

  typedef struct {bit is_row; int r; int c; logic [23:0] v; string req;} exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_cmd_vram u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_dat(ser_dat),
    .ser_clk(ser_clk), .hsync(hsync), .rd_row(rd_row), .rd_col(rd_col),
    .rd_cell(rd_cell), .rd_rowattr(rd_rowattr), .busy(busy),
    .scr_en(scr_en), .out_pol(out_pol)
  );

  always @(negedge clk) if (rst_n && busy) busy_cyc++;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [16:0] w, int n);
    ser_cs_n = 1'b0;
    tick(HALF_BIT);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      ser_clk = 1'b0;
      tick(HALF_BIT);
      ser_clk = 1'b1;
      tick(HALF_BIT);
    end
    ser_clk = 1'b0;
    tick(HALF_BIT);
    ser_cs_n = 1'b1;
    tick(8);
  endtask

  task automatic cmd(logic [15:0] w);
    send_bits({1'b0, w}, 16);
  endtask

  function automatic logic [15:0] f_addr(int r, int c, bit fill);
    return {4'h0, 4'(r), fill, 2'b00, 5'(c)};
  endfunction

  task automatic push_cell(int r, int c, logic [23:0] v, string req);
    exp_t e;
    e.is_row = 0; e.r = r; e.c = c; e.v = v; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_row(int r, logic [23:0] v, string req);
    exp_t e;
    e.is_row = 1; e.r = r; e.c = 0; e.v = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor side of the scoreboard: pop each expected item and compare
  task automatic drain();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      rd_row = 4'(e.r);
      rd_col = 5'(e.c);
      #1;
      if (e.is_row) chk({8'h0, rd_rowattr}, {8'h0, e.v}, e.req);
      else          chk({8'h0, rd_cell},    {8'h0, e.v}, e.req);
      tick(1);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int b0;
    tick(3);
    // R10 reset state
    chk(busy, 0, "R10 busy at reset");
    chk(scr_en, 0, "R10 scr_en at reset");
    chk(out_pol, 0, "R10 out_pol at reset");
    rst_n = 1'b1;
    tick(4);

    // R10 enables and polarity
    cmd(16'h50A0);
    cmd(16'hD003);
    chk(scr_en, 4'hA, "R10 scr_en load");
    chk(out_pol, 2'b11, "R10 out_pol load");
    cmd(16'h5135); // bits 11-8 nonzero: no effect
    chk(scr_en, 4'hA, "R10 scr_en other subcode");
    rst_n = 1'b0; tick(2);
    chk(scr_en, 0, "R10 scr_en cleared by reset");
    chk(out_pol, 0, "R10 out_pol cleared by reset");
    rst_n = 1'b1; tick(4);

    // R1 R3 R4 basic write and increment
    cmd(f_addr(3, 5, 0));
    cmd(16'h1ABC);
    cmd(16'h2123);
    cmd(16'h2456);
    push_cell(3, 5, 24'h123ABC, "R4 first cell");
    push_cell(3, 6, 24'h456ABC, "R4 increment keeps staged");
    // R5 row carry
    cmd(f_addr(3, 31, 0));
    cmd(16'h2777);
    cmd(16'h2888);
    push_cell(3, 31, 24'h777ABC, "R5 last column");
    push_cell(4, 0, 24'h888ABC, "R5 carry to next row");
    // R5 screen wrap
    cmd(f_addr(15, 31, 0));
    cmd(16'h2999);
    cmd(16'h2AAA);
    push_cell(15, 31, 24'h999ABC, "R5 last cell");
    push_cell(0, 0, 24'hAAAABC, "R5 wrap to origin");
    drain();

    // R6 row attributes: column ignored, no increment
    cmd(f_addr(7, 9, 0));
    cmd(16'h3321);
    cmd(16'h4654);
    cmd(16'h2111);
    push_row(7, 24'h654321, "R6 row attribute");
    push_cell(7, 9, 24'h111ABC, "R6 address not advanced");
    drain();

    // R4 staging alone does not write
    cmd(f_addr(7, 9, 0));
    cmd(16'h1555);
    push_cell(7, 9, 24'h111ABC, "R4 stage only leaves cell");
    drain();
    cmd(16'h2222);
    push_cell(7, 9, 24'h222555, "R4 write uses new stage");
    drain();

    // R2 short and long frames are discarded
    cmd(f_addr(2, 2, 0));
    cmd(16'h2AB1);
    cmd(f_addr(2, 2, 0));
    send_bits({1'b0, 16'h2CD2} >> 1, 15);
    send_bits({16'h2EF3, 1'b1}, 17);
    push_cell(2, 2, 24'hAB1555, "R2 bad frames ignored");
    drain();
    cmd(16'h2CD4);
    push_cell(2, 2, 24'hCD4555, "R2 address kept after bad frames");
    drain();

    // R8 write held during sync
    cmd(f_addr(5, 5, 0));
    cmd(16'h2101);
    cmd(f_addr(5, 5, 0));
    hsync = 1'b1;
    cmd(16'h2202);
    tick(20);
    push_cell(5, 5, 24'h101555, "R8 no write during sync");
    drain();
    hsync = 1'b0;
    tick(4);
    push_cell(5, 5, 24'h202555, "R8 write completes after sync");
    drain();

    // R7 fill with busy length
    cmd(f_addr(14, 29, 0));
    cmd(16'h2303);
    cmd(f_addr(1, 1, 0));
    cmd(16'h2404);
    cmd(f_addr(14, 30, 1));
    cmd(16'h1F0F);
    b0 = busy_cyc;
    cmd(16'h2F11);
    wait_idle();
    chk(busy_cyc - b0, 34, "R7 busy cycles equal cell count");
    push_cell(14, 30, 24'hF11F0F, "R7 fill start");
    push_cell(15, 0, 24'hF11F0F, "R7 fill crosses row");
    push_cell(15, 31, 24'hF11F0F, "R7 fill last cell");
    push_cell(14, 29, 24'h303555, "R7 cell before start untouched");
    drain();

    // R9 commands ignored while busy (fill paused by sync)
    cmd(f_addr(15, 0, 1));
    cmd(16'h1A0A);
    hsync = 1'b1;
    cmd(16'h2E22);
    tick(10);
    chk(busy, 1, "R9 busy held while paused");
    cmd(f_addr(1, 1, 0));
    cmd(16'h1BBB);
    cmd(16'h2C33);
    cmd(16'h4777);
    hsync = 1'b0;
    wait_idle();
    chk(busy, 0, "R7 busy released");
    push_cell(1, 1, 24'h404555, "R9 write during busy ignored");
    push_cell(15, 0, 24'hE22A0A, "R9 fill value unaffected");
    push_cell(15, 31, 24'hE22A0A, "R9 fill reaches end");
    push_cell(14, 31, 24'hF11F0F, "R9 earlier row untouched");
    push_row(7, 24'h654321, "R9 row write during busy ignored");
    drain();

    done = 1;
    summary();
    $finish;
  end
endmodule